// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Buffer with Status Flags

This block sits between the register file of an SPI controller and its serial shift engine. It holds the outgoing frames in a transmit FIFO and the incoming frames in a receive FIFO. Software loads the transmit FIFO with register-style writes. Each time the shift engine strobes a load, the oldest transmit entry moves into the shift register. Each time the engine signals that a transfer is complete, it delivers one received frame to the receive FIFO. Software removes received frames with register-style pop reads.

The block also keeps the status that software and the DMA or interrupt controller need. A fill flag shows that the transmit FIFO can accept data, and it is routed either to a DMA request or to an interrupt request. A transfer-complete flag and a slave-mode underflow flag are also kept. Both FIFO occupancy counters are exposed, together with the index of the transmit entry that the next transfer will send. Each flag is cleared by writing one, and each FIFO has its own flush strobe.

The fill flag is controlled by a two-state machine. In `FILL_REQ` the flag is 1. In `FILL_HOLD` the flag is 0. The machine moves from `FILL_REQ` to `FILL_HOLD` when a write-one clear arrives or when the FIFO becomes full after the update. It moves from `FILL_HOLD` to `FILL_REQ` when the FIFO is not full after the update and no clear is pending. Reset enters `FILL_REQ`.

Top module: `spi_fifo_buf`

## Requirements
- R1: After reset the following values hold: `tx_count` and `rx_count` are 0, `tx_next_ptr` is 0, `fill_flag` is 1, and `done_flag` and `unf_flag` are 0.
- R2: A push while the transmit FIFO is not full stores `push_data` at its tail and raises `tx_count` by one. A push while the FIFO holds TX_DEPTH entries (4 by default) changes neither the contents nor the count, and it raises no flag.
- R3: While the transmit FIFO is not empty, `load_data` shows the oldest entry. A `load_strobe` removes that entry, lowers `tx_count` by one and advances `tx_next_ptr` by one. A `load_strobe` on an empty FIFO has no effect.
- R4: `tx_next_ptr` wraps from TX_DEPTH-1 (3 by default) to 0.
- R5: On the edge after a `w1c_fill`, `fill_flag` becomes 0. Without a clear, `fill_flag` becomes 1 when the transmit FIFO is not full after the update and 0 when it is full.
- R6: `fill_dma_req` equals `fill_flag & fill_req_en & fill_dma_sel`. `fill_irq_req` equals `fill_flag & fill_req_en & ~fill_dma_sel`.
- R7: `xfer_done` sets `done_flag` on the next edge. `w1c_done` clears it. A set wins over a clear in the same cycle.
- R8: `xfer_start` sets `unf_flag` when it arrives with `slave_mode` at 1 and `tx_count` at 0. It has no effect otherwise. `w1c_unf` clears the flag, and a set wins over a clear in the same cycle.
- R9: `clr_tx` empties the transmit FIFO and returns `tx_next_ptr` to 0. `clr_rx` empties the receive FIFO. A flush wins over a push, load, write or pop in the same cycle.
- R10: `xfer_done` writes `rx_frame` into the receive FIFO when it is not full (RX_DEPTH is 4 by default). A frame that arrives when the FIFO is full is dropped.
- R11: A `pop_rd` on a non-empty receive FIFO places the oldest frame on `pop_data` at the next edge and lowers `rx_count` by one. A `pop_rd` on an empty receive FIFO leaves `pop_data` unchanged and `rx_count` at 0.
- R12: A push and a load that both take effect in the same cycle leave `tx_count` unchanged. A receive write and a pop that both take effect in the same cycle leave `rx_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_wr | input | 1 | Register write that pushes one transmit entry |
| push_data | input | 16 | Data for the transmit push |
| load_strobe | input | 1 | Shift engine takes the head transmit entry |
| load_data | output | 16 | Head of the transmit FIFO |
| xfer_start | input | 1 | External master begins a transfer |
| slave_mode | input | 1 | Controller operates as a slave |
| xfer_done | input | 1 | Transfer complete; `rx_frame` is valid |
| rx_frame | input | 16 | Frame received by the shift engine |
| pop_rd | input | 1 | Register read that pops one receive frame |
| pop_data | output | 16 | Last frame popped |
| w1c_fill | input | 1 | Write-one clear of the fill flag |
| w1c_done | input | 1 | Write-one clear of the transfer-complete flag |
| w1c_unf | input | 1 | Write-one clear of the underflow flag |
| clr_tx | input | 1 | Flush the transmit FIFO |
| clr_rx | input | 1 | Flush the receive FIFO |
| fill_req_en | input | 1 | Enable for the fill request |
| fill_dma_sel | input | 1 | 1 routes the fill request to DMA, 0 routes it to the interrupt |
| fill_flag | output | 1 | Transmit FIFO can take data |
| done_flag | output | 1 | Transfer-complete flag |
| unf_flag | output | 1 | Transmit underflow flag |
| tx_count | output | 3 | Transmit entries held |
| rx_count | output | 3 | Receive entries held |
| tx_next_ptr | output | 2 | Index of the next transmit entry to send |
| fill_dma_req | output | 1 | Fill request to DMA |
| fill_irq_req | output | 1 | Fill request to the interrupt controller |

## Verification
Two pairs of operations can share one cycle. A software push can arrive on the same edge as a shift-engine load, and a receive write from a completed transfer can arrive on the same edge as a software pop. The bench raises both strobes of each pair on one edge with a partly filled FIFO. It then checks that the counter keeps its value, that the next-pointer still advances, and that the popped frame is the older one while the new frame is queued behind it. The same-cycle cases of write-one clear against a set, and of flush against a push, are exercised in the same way.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    // Fill-flag controller states
    typedef enum logic {
        FILL_REQ  = 1'b0,   // transmit FIFO can accept data, flag shown as 1
        FILL_HOLD = 1'b1    // flag cleared by software or FIFO full
    } fill_state_e;
endpackage

// File: rtl/spi_tx_fifo.sv
module spi_tx_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          drain,
    input  logic          flush,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count,
    output logic [PW-1:0] rd_ptr,
    output logic          full_next
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] count_nxt;
    logic          do_push;
    logic          do_drain;

    assign do_push   = push  && (count != FULL_CNT);
    assign do_drain  = drain && (count != '0);
    assign head_data = mem[rd_ptr];

    always_comb begin
        if (flush) begin
            count_nxt = '0;
        end else begin
            unique case ({do_push, do_drain})
                2'b10:   count_nxt = count + CW'(1);
                2'b01:   count_nxt = count - CW'(1);
                default: count_nxt = count;
            endcase
        end
    end

    assign full_next = (count_nxt == FULL_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            count <= count_nxt;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (do_push)
                    wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + PW'(1);
                if (do_drain)
                    rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + PW'(1);
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[g] <= '0;
                else if (do_push && !flush && (wr_ptr == PW'(g)))
                    mem[g] <= push_data;
            end
        end
    endgenerate
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          do_wr;
    logic          do_pop;

    assign do_wr  = wr  && (count != FULL_CNT) && !flush;
    assign do_pop = pop && (count != '0) && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            pop_data <= '0;
        end else if (flush) begin
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            unique case ({do_wr, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
            if (do_wr)
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + PW'(1);
            if (do_pop) begin
                pop_data <= mem[rd_ptr];
                rd_ptr   <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + PW'(1);
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[g] <= '0;
                else if (do_wr && (wr_ptr == PW'(g)))
                    mem[g] <= wr_data;
            end
        end
    endgenerate
endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags
    import spi_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_full_next,
    input  logic w1c_fill,
    input  logic set_done,
    input  logic w1c_done,
    input  logic set_unf,
    input  logic w1c_unf,
    input  logic req_en,
    input  logic dma_sel,
    output logic fill_flag,
    output logic done_flag,
    output logic unf_flag,
    output logic dma_req,
    output logic irq_req
);
    fill_state_e state_q;
    fill_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FILL_REQ;
        else
            state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_REQ:  if (w1c_fill || tx_full_next)   state_d = FILL_HOLD;
            FILL_HOLD: if (!w1c_fill && !tx_full_next) state_d = FILL_REQ;
            default:   state_d = FILL_REQ;
        endcase
    end

    // Outputs
    always_comb begin
        fill_flag = (state_q == FILL_REQ);
        dma_req   = fill_flag && req_en && dma_sel;
        irq_req   = fill_flag && req_en && !dma_sel;
    end

    // Sticky flags: set has priority over write-one clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            unf_flag  <= 1'b0;
        end else begin
            if (set_done)      done_flag <= 1'b1;
            else if (w1c_done) done_flag <= 1'b0;
            if (set_unf)       unf_flag  <= 1'b1;
            else if (w1c_unf)  unf_flag  <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
    parameter int DW       = 16,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    parameter int TX_PW    = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1,
    parameter int TX_CW    = $clog2(TX_DEPTH + 1),
    parameter int RX_CW    = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_wr,
    input  logic [DW-1:0]    push_data,
    input  logic             load_strobe,
    output logic [DW-1:0]    load_data,
    input  logic             xfer_start,
    input  logic             slave_mode,
    input  logic             xfer_done,
    input  logic [DW-1:0]    rx_frame,
    input  logic             pop_rd,
    output logic [DW-1:0]    pop_data,
    input  logic             w1c_fill,
    input  logic             w1c_done,
    input  logic             w1c_unf,
    input  logic             clr_tx,
    input  logic             clr_rx,
    input  logic             fill_req_en,
    input  logic             fill_dma_sel,
    output logic             fill_flag,
    output logic             done_flag,
    output logic             unf_flag,
    output logic [TX_CW-1:0] tx_count,
    output logic [RX_CW-1:0] rx_count,
    output logic [TX_PW-1:0] tx_next_ptr,
    output logic             fill_dma_req,
    output logic             fill_irq_req
);
    logic tx_full_next;
    logic unf_hit;

    assign unf_hit = xfer_start && slave_mode && (tx_count == '0);

    spi_tx_fifo #(.DW(DW), .DEPTH(TX_DEPTH), .PW(TX_PW), .CW(TX_CW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_wr),
        .push_data (push_data),
        .drain     (load_strobe),
        .flush     (clr_tx),
        .head_data (load_data),
        .count     (tx_count),
        .rd_ptr    (tx_next_ptr),
        .full_next (tx_full_next)
    );

    spi_rx_fifo #(.DW(DW), .DEPTH(RX_DEPTH), .CW(RX_CW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (xfer_done),
        .wr_data  (rx_frame),
        .pop      (pop_rd),
        .flush    (clr_rx),
        .pop_data (pop_data),
        .count    (rx_count)
    );

    spi_status_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_full_next (tx_full_next),
        .w1c_fill     (w1c_fill),
        .set_done     (xfer_done),
        .w1c_done     (w1c_done),
        .set_unf      (unf_hit),
        .w1c_unf      (w1c_unf),
        .req_en       (fill_req_en),
        .dma_sel      (fill_dma_sel),
        .fill_flag    (fill_flag),
        .done_flag    (done_flag),
        .unf_flag     (unf_flag),
        .dma_req      (fill_dma_req),
        .irq_req      (fill_irq_req)
    );
endmodule

// File: rtl/spi_fifo_buf_chk.sv
module spi_fifo_buf_chk #(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    parameter int TX_PW    = 2,
    parameter int TX_CW    = 3,
    parameter int RX_CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_wr,
    input logic             load_strobe,
    input logic             xfer_start,
    input logic             slave_mode,
    input logic             xfer_done,
    input logic             clr_tx,
    input logic             clr_rx,
    input logic             fill_flag,
    input logic             done_flag,
    input logic             unf_flag,
    input logic [TX_CW-1:0] tx_count,
    input logic [RX_CW-1:0] rx_count,
    input logic [TX_PW-1:0] tx_next_ptr,
    input logic             fill_dma_req,
    input logic             fill_irq_req
);
    localparam logic [TX_CW-1:0] TX_FULL = TX_CW'(TX_DEPTH);
    localparam logic [RX_CW-1:0] RX_FULL = RX_CW'(RX_DEPTH);
    localparam logic [TX_PW-1:0] TX_LAST = TX_PW'(TX_DEPTH - 1);

    a_r2_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push_wr && !load_strobe && !clr_tx && tx_count == TX_FULL) |=> (tx_count == TX_FULL));

    a_r3_load_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strobe && !push_wr && !clr_tx && tx_count != '0) |=> (tx_count == $past(tx_count) - TX_CW'(1)));

    a_r4_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strobe && !clr_tx && tx_count != '0 && tx_next_ptr == TX_LAST) |=> (tx_next_ptr == '0));

    a_r5_full_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == TX_FULL) |-> !fill_flag);

    a_r6_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_dma_req, fill_irq_req}));

    a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> done_flag);

    a_r8_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && slave_mode && tx_count == '0) |=> unf_flag);

    a_r9_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tx |=> (tx_count == '0 && tx_next_ptr == '0));

    a_r9_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rx |=> (rx_count == '0));

    a_r10_rx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= RX_FULL);
endmodule

bind spi_fifo_buf spi_fifo_buf_chk #(
    .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .TX_PW(TX_PW), .TX_CW(TX_CW), .RX_CW(RX_CW)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_wr      (push_wr),
    .load_strobe  (load_strobe),
    .xfer_start   (xfer_start),
    .slave_mode   (slave_mode),
    .xfer_done    (xfer_done),
    .clr_tx       (clr_tx),
    .clr_rx       (clr_rx),
    .fill_flag    (fill_flag),
    .done_flag    (done_flag),
    .unf_flag     (unf_flag),
    .tx_count     (tx_count),
    .rx_count     (rx_count),
    .tx_next_ptr  (tx_next_ptr),
    .fill_dma_req (fill_dma_req),
    .fill_irq_req (fill_irq_req)
);

// File: tb/spi_fifo_buf_tb.sv
`timescale 1ns/1ps
module spi_fifo_buf_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_wr = 0, load_strobe = 0, xfer_start = 0, slave_mode = 0, xfer_done = 0;
    logic [15:0] push_data = '0, rx_frame = '0;
    logic        pop_rd = 0, w1c_fill = 0, w1c_done = 0, w1c_unf = 0, clr_tx = 0, clr_rx = 0;
    logic        fill_req_en = 0, fill_dma_sel = 0;
    logic [15:0] load_data, pop_data;
    logic        fill_flag, done_flag, unf_flag, fill_dma_req, fill_irq_req;
    logic [2:0]  tx_count, rx_count;
    logic [1:0]  tx_next_ptr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_fifo_buf dut_i (
        .clk(clk), .rst_n(rst_n), .push_wr(push_wr), .push_data(push_data),
        .load_strobe(load_strobe), .load_data(load_data), .xfer_start(xfer_start),
        .slave_mode(slave_mode), .xfer_done(xfer_done), .rx_frame(rx_frame),
        .pop_rd(pop_rd), .pop_data(pop_data), .w1c_fill(w1c_fill), .w1c_done(w1c_done),
        .w1c_unf(w1c_unf), .clr_tx(clr_tx), .clr_rx(clr_rx), .fill_req_en(fill_req_en),
        .fill_dma_sel(fill_dma_sel), .fill_flag(fill_flag), .done_flag(done_flag),
        .unf_flag(unf_flag), .tx_count(tx_count), .rx_count(rx_count),
        .tx_next_ptr(tx_next_ptr), .fill_dma_req(fill_dma_req), .fill_irq_req(fill_irq_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // advance past one rising edge; inputs change and outputs are read away from the edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R1 tx_count", tx_count, 0);
        chk("R1 rx_count", rx_count, 0);
        chk("R1 next_ptr", tx_next_ptr, 0);
        chk("R1 fill_flag", fill_flag, 1);
        chk("R1 done_flag", done_flag, 0);
        chk("R1 unf_flag", unf_flag, 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 4; i++) begin
            push_wr = 1; push_data = 16'hA000 + 16'(i);
            step();
        end
        push_wr = 0;
        chk("R2 count after 4 pushes", tx_count, 4);
        chk("R5 flag low when full", fill_flag, 0);
        push_wr = 1; push_data = 16'hBEEF;
        step();
        push_wr = 0;
        chk("R2 full push count", tx_count, 4);
        chk("R2 full push head", load_data, 16'hA000);
        chk("R2 no flag on full push", {unf_flag, done_flag}, 0);
    endtask

    task automatic t_drain();
        for (int i = 0; i < 4; i++) begin
            chk("R3 head data", load_data, 16'hA000 + 16'(i));
            chk("R3 next_ptr", tx_next_ptr, i);
            load_strobe = 1;
            step();
            load_strobe = 0;
            chk("R3 count after load", tx_count, 3 - i);
            chk("R5 flag set when not full", fill_flag, 1);
        end
        chk("R4 next_ptr wrapped", tx_next_ptr, 0);
        load_strobe = 1;
        step();
        load_strobe = 0;
        chk("R3 empty load ignored count", tx_count, 0);
        chk("R3 empty load ignored ptr", tx_next_ptr, 0);
    endtask

    task automatic t_fill_w1c_and_req();
        w1c_fill = 1;
        step();
        w1c_fill = 0;
        chk("R5 w1c clears flag", fill_flag, 0);
        fill_req_en = 1; fill_dma_sel = 1; #1;
        chk("R6 no request while flag low", {fill_dma_req, fill_irq_req}, 2'b00);
        step();
        chk("R5 flag returns when not full", fill_flag, 1);
        chk("R6 dma route", {fill_dma_req, fill_irq_req}, 2'b10);
        fill_dma_sel = 0; #1;
        chk("R6 irq route", {fill_dma_req, fill_irq_req}, 2'b01);
        fill_req_en = 0; #1;
        chk("R6 disabled", {fill_dma_req, fill_irq_req}, 2'b00);
    endtask

    task automatic t_tx_same_cycle();
        // pointer is at 0 after the wrap
        push_wr = 1; push_data = 16'hC000; step();
        push_data = 16'hC001; step();
        push_wr = 0;
        chk("R2 two entries", tx_count, 2);
        push_wr = 1; push_data = 16'hC002; load_strobe = 1;
        step();
        push_wr = 0; load_strobe = 0;
        chk("R12 push+load count", tx_count, 2);
        chk("R12 push+load ptr", tx_next_ptr, 1);
        chk("R12 push+load head", load_data, 16'hC001);
        clr_tx = 1; push_wr = 1; push_data = 16'hDEAD;
        step();
        clr_tx = 0; push_wr = 0;
        chk("R9 tx flush count", tx_count, 0);
        chk("R9 tx flush ptr", tx_next_ptr, 0);
        step();
        chk("R5 flag after flush", fill_flag, 1);
    endtask

    task automatic t_status_flags();
        xfer_done = 1; rx_frame = 16'h1111;
        step();
        xfer_done = 0;
        chk("R7 done set", done_flag, 1);
        xfer_done = 1; w1c_done = 1;
        step();
        xfer_done = 0; w1c_done = 0;
        chk("R7 set wins over clear", done_flag, 1);
        w1c_done = 1;
        step();
        w1c_done = 0;
        chk("R7 w1c clears", done_flag, 0);
        slave_mode = 1; xfer_start = 1;
        step();
        xfer_start = 0;
        chk("R8 underflow set", unf_flag, 1);
        w1c_unf = 1;
        step();
        w1c_unf = 0;
        chk("R8 w1c clears", unf_flag, 0);
        slave_mode = 0; xfer_start = 1;
        step();
        xfer_start = 0;
        chk("R8 master mode no underflow", unf_flag, 0);
        push_wr = 1; push_data = 16'h7777; step(); push_wr = 0;
        slave_mode = 1; xfer_start = 1;
        step();
        xfer_start = 0; slave_mode = 0;
        chk("R8 non-empty no underflow", unf_flag, 0);
        clr_tx = 1; step(); clr_tx = 0;
        chk("R10 two frames queued", rx_count, 2);
        clr_rx = 1; pop_rd = 1; xfer_done = 1;
        step();
        clr_rx = 0; pop_rd = 0; xfer_done = 0;
        chk("R9 rx flush", rx_count, 0);
        chk("R9 flush blocks pop", pop_data, 0);
    endtask

    task automatic t_rx();
        for (int i = 0; i < 4; i++) begin
            xfer_done = 1; rx_frame = 16'h5000 + 16'(i);
            step();
        end
        rx_frame = 16'h5999;
        step();
        xfer_done = 0;
        chk("R10 full rx count", rx_count, 4);
        pop_rd = 1;
        step();
        pop_rd = 0;
        chk("R11 pop oldest", pop_data, 16'h5000);
        chk("R11 count after pop", rx_count, 3);
        pop_rd = 1; xfer_done = 1; rx_frame = 16'h5004;
        step();
        pop_rd = 0; xfer_done = 0;
        chk("R12 write+pop count", rx_count, 3);
        chk("R12 write+pop data", pop_data, 16'h5001);
        for (int i = 2; i < 5; i++) begin
            pop_rd = 1;
            step();
            pop_rd = 0;
            chk("R10 order, overflow frame dropped", pop_data, 16'h5000 + 16'(i));
        end
        chk("R11 drained", rx_count, 0);
        pop_rd = 1;
        step();
        pop_rd = 0;
        chk("R11 empty pop keeps data", pop_data, 16'h5004);
        chk("R11 empty pop count", rx_count, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_drain();
        t_fill_w1c_and_req();
        t_tx_same_cycle();
        t_status_flags();
        t_rx();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule